// File: doc/BRIEF.md
# Single-Slope Converter Counting Controller

This block is the digital half of a ramp-and-compare voltmeter with three decimal digits. An external analog comparator compares the unknown input against a rising ramp. The block receives the comparator result as an asynchronous digital level. While that level is high, the block counts clock cycles in three cascaded BCD decade stages for units, tens and hundreds. With a 1 MHz clock and a 1 V/ms ramp, one count is one millivolt, and full scale is 999.

When the comparator drops low, counting stops. A controller then issues a one-cycle strobe that copies the three digits and an over-range flag into holding registers. In the cycle after the strobe it issues a one-cycle clear. The clear empties the counters and tells the external ramp to restart, so conversions follow one another without operator action. The held result drives the BCD outputs and three seven-segment patterns. These keep showing the previous reading while the next conversion runs.

The controller has four states: `ST_IDLE`, `ST_CLEAR`, `ST_COUNT` and `ST_STROBE`. The transitions are:
- Power-up reset leads to `ST_IDLE`.
- `start_req` moves any state to `ST_CLEAR`.
- `ST_CLEAR` always moves to `ST_COUNT`.
- `ST_COUNT` moves to `ST_STROBE` on a detected comparator fall.
- `ST_STROBE` always moves to `ST_CLEAR`.

Top module: `ramp_adc_ctrl`

## Requirements
- R1: The count is held as three BCD digits (units, tens, hundreds). Each digit stays in the range 0 to 9, and a digit passing 9 returns to 0 and advances the next digit, so the range is 000 to 999.
- R2: While `start_req` is high at a clock edge, the controller enters the clear state from any state. `ramp_clr` is high for the following cycle, and the counters read zero afterwards.
- R3: `cmp_in` passes through a two-flop synchroniser. In the counting state, the count rises by one per clock while the synchronised level is high. A conversion result therefore equals the number of rising clock edges at which `cmp_in` was high.
- R4: Once the synchronised comparator level is low, no further increment occurs.
- R5: The clock edge after a synchronised high-to-low transition enters the strobe state. `strobe` is high for exactly one cycle, and the held digits load at the end of that cycle.
- R6: `ramp_clr` is high for exactly one cycle, in the cycle after `strobe`. Counting then resumes with no further input.
- R7: An increment requested at 999 leaves the count at 999 and sets an over-range flag. The flag is held with the digits on `over_range`, and the next clear empties it.
- R8: The held digits, `over_range` and segment outputs change only at the end of a strobe cycle. They keep the previous result during the following conversion.
- R9: Each segment output is active high, with bit 0 = a through bit 6 = g. Codes 0..9 give 0x3F, 0x06, 0x5B, 0x4F, 0x66, 0x6D, 0x7D, 0x07, 0x7F and 0x6F.
- R10: After power-up reset, `result_valid` is 0, the held digits are 0 and all segments are 0 (blank). The first strobe sets `result_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock |
| rst_n | input | 1 | Active-low power-up reset |
| start_req | input | 1 | Manual restart request |
| cmp_in | input | 1 | Asynchronous comparator result, high while the ramp is below the input |
| ramp_clr | output | 1 | One-cycle pulse that clears the counters and restarts the ramp |
| strobe | output | 1 | One-cycle pulse that loads the held result |
| result_valid | output | 1 | A result has been held since power-up |
| over_range | output | 1 | Held result saturated at 999 |
| dig_units | output | 4 | Held BCD units digit |
| dig_tens | output | 4 | Held BCD tens digit |
| dig_hundreds | output | 4 | Held BCD hundreds digit |
| seg_units | output | 7 | Segments for units, bit 0 = a |
| seg_tens | output | 7 | Segments for tens, bit 0 = a |
| seg_hundreds | output | 7 | Segments for hundreds, bit 0 = a |

## Verification
Two functions can fall in the same cycle. One is the end of counting, where the last increment coincides with the comparator fall reaching the synchroniser output. The other is saturation, where the increment request at 999 coincides with the digit carry.

The bench provokes the first by ending comparator pulses of known length, including lengths that trigger multi-digit carries (10, 100, 709). It judges the case by requiring the held result to equal the pulse length exactly. It provokes the second with pulse lengths of 999 and 1000, which must read 999 without and with the over-range flag, and with a longer pulse that must stay at 999.

// File: rtl/ramp_adc_pkg.sv
package ramp_adc_pkg;
    localparam int NDIG   = 3;
    localparam int DIG_W  = 4;
    localparam int SEG_W  = 7;
    localparam int SYNC_N = 2;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_CLEAR,
        ST_COUNT,
        ST_STROBE
    } conv_state_t;
endpackage

// File: rtl/cmp_sync.sv
module cmp_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], async_in};
    end

    assign sync_out = chain_q[STAGES-1];
endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
    import ramp_adc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_req,
    input  logic cmp_lvl,
    input  logic cmp_fall,
    output logic cnt_en,
    output logic load_pulse,
    output logic clr_pulse
);
    conv_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   state_d = ST_IDLE;
            ST_CLEAR:  state_d = ST_COUNT;
            ST_COUNT:  if (cmp_fall) state_d = ST_STROBE;
            ST_STROBE: state_d = ST_CLEAR;
            default:   state_d = ST_IDLE;
        endcase
        if (start_req) state_d = ST_CLEAR;
    end

    always_comb begin
        cnt_en     = 1'b0;
        load_pulse = 1'b0;
        clr_pulse  = 1'b0;
        unique case (state_q)
            ST_IDLE:   ;
            ST_CLEAR:  clr_pulse  = 1'b1;
            ST_COUNT:  cnt_en     = cmp_lvl;
            ST_STROBE: load_pulse = 1'b1;
            default:   ;
        endcase
    end
endmodule

// File: rtl/bcd_chain.sv
module bcd_chain #(
    parameter int NDIG  = 3,
    parameter int DIG_W = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       clr,
    input  logic                       en,
    output logic [NDIG-1:0][DIG_W-1:0] digits,
    output logic                       sat
);
    localparam logic [DIG_W-1:0] NINE = DIG_W'(9);

    logic [NDIG:0]   carry;
    logic [NDIG-1:0] is_nine;
    logic            all_nine;

    assign all_nine = &is_nine;
    assign carry[0] = en & ~all_nine;

    for (genvar i = 0; i < NDIG; i++) begin : g_dig
        assign is_nine[i]  = (digits[i] == NINE);
        assign carry[i+1]  = carry[i] & is_nine[i];

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        digits[i] <= '0;
            else if (clr)      digits[i] <= '0;
            else if (carry[i]) digits[i] <= is_nine[i] ? '0 : digits[i] + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              sat <= 1'b0;
        else if (clr)            sat <= 1'b0;
        else if (en && all_nine) sat <= 1'b1;
    end
endmodule

// File: rtl/seg7_dec.sv
module seg7_dec #(
    parameter int DIG_W = 4,
    parameter int SEG_W = 7
) (
    input  logic [DIG_W-1:0] code,
    input  logic             blank,
    output logic [SEG_W-1:0] seg
);
    always_comb begin
        unique case (code)
            4'd0:    seg = 7'h3F;
            4'd1:    seg = 7'h06;
            4'd2:    seg = 7'h5B;
            4'd3:    seg = 7'h4F;
            4'd4:    seg = 7'h66;
            4'd5:    seg = 7'h6D;
            4'd6:    seg = 7'h7D;
            4'd7:    seg = 7'h07;
            4'd8:    seg = 7'h7F;
            4'd9:    seg = 7'h6F;
            default: seg = 7'h00;
        endcase
        if (blank) seg = '0;
    end
endmodule

// File: rtl/ramp_adc_ctrl.sv
module ramp_adc_ctrl
    import ramp_adc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_req,
    input  logic       cmp_in,
    output logic       ramp_clr,
    output logic       strobe,
    output logic       result_valid,
    output logic       over_range,
    output logic [3:0] dig_units,
    output logic [3:0] dig_tens,
    output logic [3:0] dig_hundreds,
    output logic [6:0] seg_units,
    output logic [6:0] seg_tens,
    output logic [6:0] seg_hundreds
);
    logic cmp_lvl, cmp_lvl_d, cmp_fall;
    logic cnt_en, load_pulse, clr_pulse, sat;
    logic [NDIG-1:0][DIG_W-1:0] cnt_dig, held_dig;
    logic [NDIG-1:0][SEG_W-1:0] seg_all;
    logic held_ovr, held_vld;

    cmp_sync #(.STAGES(SYNC_N)) i_sync (
        .clk(clk), .rst_n(rst_n), .async_in(cmp_in), .sync_out(cmp_lvl)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cmp_lvl_d <= 1'b0;
        else        cmp_lvl_d <= cmp_lvl;
    end
    assign cmp_fall = cmp_lvl_d & ~cmp_lvl;

    adc_seq_fsm i_fsm (
        .clk(clk), .rst_n(rst_n), .start_req(start_req),
        .cmp_lvl(cmp_lvl), .cmp_fall(cmp_fall),
        .cnt_en(cnt_en), .load_pulse(load_pulse), .clr_pulse(clr_pulse)
    );

    bcd_chain #(.NDIG(NDIG), .DIG_W(DIG_W)) i_cnt (
        .clk(clk), .rst_n(rst_n), .clr(clr_pulse), .en(cnt_en),
        .digits(cnt_dig), .sat(sat)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            held_dig <= '0;
            held_ovr <= 1'b0;
            held_vld <= 1'b0;
        end else if (load_pulse) begin
            held_dig <= cnt_dig;
            held_ovr <= sat;
            held_vld <= 1'b1;
        end
    end

    for (genvar i = 0; i < NDIG; i++) begin : g_seg
        seg7_dec #(.DIG_W(DIG_W), .SEG_W(SEG_W)) i_dec (
            .code(held_dig[i]), .blank(~held_vld), .seg(seg_all[i])
        );
    end

    assign ramp_clr     = clr_pulse;
    assign strobe       = load_pulse;
    assign result_valid = held_vld;
    assign over_range   = held_ovr;
    assign dig_units    = held_dig[0];
    assign dig_tens     = held_dig[1];
    assign dig_hundreds = held_dig[2];
    assign seg_units    = seg_all[0];
    assign seg_tens     = seg_all[1];
    assign seg_hundreds = seg_all[2];
endmodule

// File: rtl/ramp_adc_chk.sv
module ramp_adc_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       start_req,
    input logic       ramp_clr,
    input logic       strobe,
    input logic       result_valid,
    input logic       over_range,
    input logic [3:0] dig_units,
    input logic [3:0] dig_tens,
    input logic [3:0] dig_hundreds,
    input logic [6:0] seg_units,
    input logic [6:0] seg_tens,
    input logic [6:0] seg_hundreds
);
    AST_DIGITS_BCD: assert property (@(posedge clk) disable iff (!rst_n)
        (dig_units <= 4'd9) && (dig_tens <= 4'd9) && (dig_hundreds <= 4'd9)); // R1
    AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        start_req |=> ramp_clr); // R2
    AST_STROBE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && !start_req) |=> !strobe); // R5
    AST_CLR_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |=> ramp_clr); // R6
    AST_CLR_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (ramp_clr && !start_req) |=> !ramp_clr); // R6
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        over_range |-> (dig_units == 4'd9 && dig_tens == 4'd9 && dig_hundreds == 4'd9)); // R7
    AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !strobe |=> $stable({dig_units, dig_tens, dig_hundreds, over_range, result_valid})); // R8
    AST_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
        !result_valid |-> (seg_units == 7'h0 && seg_tens == 7'h0 && seg_hundreds == 7'h0)); // R10
endmodule

bind ramp_adc_ctrl ramp_adc_chk i_chk (
    .clk(clk), .rst_n(rst_n), .start_req(start_req), .ramp_clr(ramp_clr),
    .strobe(strobe), .result_valid(result_valid), .over_range(over_range),
    .dig_units(dig_units), .dig_tens(dig_tens), .dig_hundreds(dig_hundreds),
    .seg_units(seg_units), .seg_tens(seg_tens), .seg_hundreds(seg_hundreds)
);

// File: tb/test_ramp_adc_ctrl.sv
module test_ramp_adc_ctrl;
    localparam time CLK_PERIOD = 10ns;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_req = 1'b0;
    logic cmp_in = 1'b0;
    logic ramp_clr, strobe, result_valid, over_range;
    logic [3:0] dig_units, dig_tens, dig_hundreds;
    logic [6:0] seg_units, seg_tens, seg_hundreds;

    int n_tests = 0;
    int n_fail  = 0;
    int prev_val = 0;
    bit prev_ovr = 1'b0;
    bit done = 1'b0;

    typedef struct { int val; bit ovr; } exp_t;
    exp_t exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    ramp_adc_ctrl i_ramp_adc_ctrl (
        .clk(clk), .rst_n(rst_n), .start_req(start_req), .cmp_in(cmp_in),
        .ramp_clr(ramp_clr), .strobe(strobe), .result_valid(result_valid),
        .over_range(over_range), .dig_units(dig_units), .dig_tens(dig_tens),
        .dig_hundreds(dig_hundreds), .seg_units(seg_units), .seg_tens(seg_tens),
        .seg_hundreds(seg_hundreds)
    );

    function automatic logic [6:0] seg_of(int d);
        case (d)
            0: return 7'h3F; 1: return 7'h06; 2: return 7'h5B; 3: return 7'h4F;
            4: return 7'h66; 5: return 7'h6D; 6: return 7'h7D; 7: return 7'h07;
            8: return 7'h7F; 9: return 7'h6F; default: return 7'h00;
        endcase
    endfunction

    function automatic int shown();
        return dig_hundreds * 100 + dig_tens * 10 + dig_units;
    endfunction

    task automatic check(string req, int act, int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // driver: one comparator pulse of n clocks, expectation pushed to the scoreboard
    task automatic convert(int n);
        exp_t e;
        e.val = (n > 999) ? 999 : n;
        e.ovr = (n > 999);
        exp_q.push_back(e);
        cmp_in = 1'b1;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (i == n / 2) begin
                check("R8 hold value", shown(), prev_val);
                check("R8 hold flag", int'(over_range), int'(prev_ovr));
            end
        end
        cmp_in = 1'b0;
        repeat (10) @(negedge clk);
    endtask

    // monitor: pops an expectation at each strobe and compares the held result
    initial begin
        forever begin
            @(negedge clk);
            if (strobe) begin
                exp_t e;
                if (exp_q.size() == 0) begin
                    check("R5 unexpected strobe", 1, 0);
                end else begin
                    e = exp_q.pop_front();
                    @(negedge clk);
                    check("R3 R4 R1 value", shown(), e.val);
                    check("R7 over_range", int'(over_range), int'(e.ovr));
                    check("R10 valid", int'(result_valid), 1);
                    check("R9 seg units", int'(seg_units), int'(seg_of(e.val % 10)));
                    check("R9 seg tens", int'(seg_tens), int'(seg_of((e.val / 10) % 10)));
                    check("R9 seg hundreds", int'(seg_hundreds), int'(seg_of(e.val / 100)));
                    check("R6 clr after strobe", int'(ramp_clr), 1);
                    check("R5 strobe width", int'(strobe), 0);
                    @(negedge clk);
                    check("R6 clr width", int'(ramp_clr), 0);
                    prev_val = e.val;
                    prev_ovr = e.ovr;
                end
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R10 valid at reset", int'(result_valid), 0);
        check("R10 digits at reset", shown(), 0);
        check("R10 blank segs", int'({seg_units, seg_tens, seg_hundreds}), 0);
        check("R2 no clr before start", int'(ramp_clr), 0);
        start_req = 1'b1;
        @(negedge clk);
        start_req = 1'b0;
        check("R2 clr after start", int'(ramp_clr), 1);
        @(negedge clk);
        check("R2 clr one cycle", int'(ramp_clr), 0);
        repeat (2) @(negedge clk);
        convert(345);
        convert(1);
        convert(10);
        convert(100);
        convert(709);
        convert(999);
        convert(1000);
        convert(1020);
        convert(90);
        repeat (5) @(negedge clk);
        check("R5 all results strobed", exp_q.size(), 0);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule